// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block forms a 20-bit physical memory address from a 16-bit segment base and a 16-bit offset. The segment value is moved up by four bit positions and the offset is added to it. Each segment is therefore a 64 KB window that can start at any 16-byte boundary. The block holds four segment registers: code, data, extra and stack. Each one is loaded through a single write port and is cleared by reset.

The caller supplies an offset and a code that names the register the offset came from. The block picks the segment that belongs with that register. The caller can also force a different segment with an override. The only exception is the destination pointer of a string transfer, which is always tied to the extra segment. The address path is purely combinational from the current register contents. A register write becomes visible on the clock edge that follows it.

Top module: `seg_addr_gen`

## Requirements
- R1: `phys_addr` equals (selected segment × 16 + offset), truncated to 20 bits. For example, segment 34BAh with offset 8AB4h gives 3D654h.
- R2: A sum above FFFFFh wraps to low memory. For example, segment FFFFh with offset 0010h gives 00000h, and with offset FFFFh gives 0FFEFh.
- R3: While `rst_n` is low and after reset, all four segment registers are 0000h, so `phys_addr` equals the zero-extended offset for every source.
- R4: A write with `seg_wr_en`=1 takes effect on the next rising clock edge. During the write cycle itself, `phys_addr` still uses the old register value.
- R5: A write changes only the register named by `seg_wr_sel` (0 code, 1 data, 2 extra, 3 stack). The other three registers keep their values.
- R6: With no override, the segment is chosen from `ofs_src` as follows:
  - 0: instruction pointer → code
  - 1: stack pointer → stack
  - 2: base pointer → stack
  - 3: base register → data
  - 4: source index → data
  - 5: string destination index → extra
  - 6: destination index in general use → data
  - 7: direct displacement → data
- R7: When `ovr_en`=1 and `ofs_src`≠5, the segment named by `ovr_sel` is used instead of the default. `ovr_sel` uses the same codes as R5.
- R8: When `ofs_src`=5, `ovr_en` and `ovr_sel` have no effect and the extra segment is always used.
- R9: `phys_addr` follows changes on `ofs_val`, `ofs_src`, `ovr_en` and `ovr_sel` within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for segment register writes |
| rst_n | input | 1 | Asynchronous active-low reset, clears the segment registers |
| seg_wr_en | input | 1 | Segment register write strobe |
| seg_wr_sel | input | 2 | Register to write (0 code, 1 data, 2 extra, 3 stack) |
| seg_wr_data | input | 16 | New segment value |
| ofs_src | input | 3 | Code of the register that supplied the offset |
| ofs_val | input | 16 | Offset value |
| ovr_en | input | 1 | Segment override request |
| ovr_sel | input | 2 | Segment forced by the override |
| phys_addr | output | 20 | Physical address |

## Verification
A register write and an address lookup through that same register can fall in the same cycle. The bench provokes this by raising the write strobe with a new value while the address inputs point at the register being written. It then checks that `phys_addr` still carries the old base before the edge and the new base after it. A second such meeting is an override request arriving together with a string destination source. The bench sweeps every override selection against that source and expects the extra segment each time, while every other source must follow the override.

// File: rtl/seg_pkg.sv
package seg_pkg;
  typedef enum logic [1:0] {
    SEG_CODE  = 2'd0,
    SEG_DATA  = 2'd1,
    SEG_EXTRA = 2'd2,
    SEG_STACK = 2'd3
  } seg_id_e;

  typedef enum logic [2:0] {
    SRC_IPTR   = 3'd0,
    SRC_SPTR   = 3'd1,
    SRC_BPTR   = 3'd2,
    SRC_BASE   = 3'd3,
    SRC_SIDX   = 3'd4,
    SRC_STRDST = 3'd5,
    SRC_DIDX   = 3'd6,
    SRC_DISP   = 3'd7
  } ofs_src_e;

  localparam int NUM_SEGS = 4;
  localparam int SEL_W    = 2;
  localparam int SRC_W    = 3;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile #(
  parameter int NSEG  = 4,
  parameter int SEG_W = 16,
  localparam int IDX_W = $clog2(NSEG)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_sel,
  input  logic [SEG_W-1:0]            wr_data,
  output logic [NSEG-1:0][SEG_W-1:0]  seg_q
);
  for (genvar g = 0; g < NSEG; g++) begin : g_reg
    logic hit;
    assign hit = wr_en && (wr_sel == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   seg_q[g] <= '0;
      else if (hit) seg_q[g] <= wr_data;
    end
  end

  // R4
  wr_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (seg_q[$past(wr_sel)] == $past(wr_data)));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(seg_q));
endmodule

// File: rtl/seg_selector.sv
module seg_selector
  import seg_pkg::*;
(
  input  logic [SRC_W-1:0] src,
  input  logic             ovr_en,
  input  logic [SEL_W-1:0] ovr_sel,
  output logic [SEL_W-1:0] seg_sel,
  output logic             ovr_taken
);
  function automatic seg_id_e default_seg(input logic [SRC_W-1:0] s);
    case (ofs_src_e'(s))
      SRC_IPTR:             return SEG_CODE;
      SRC_SPTR, SRC_BPTR:   return SEG_STACK;
      SRC_STRDST:           return SEG_EXTRA;
      default:              return SEG_DATA;
    endcase
  endfunction

  logic locked;
  assign locked    = (ofs_src_e'(src) == SRC_STRDST);
  assign ovr_taken = ovr_en && !locked;

  always_comb begin
    if (ovr_taken) seg_sel = ovr_sel;
    else           seg_sel = default_seg(src);
  end
endmodule

// File: rtl/seg_adder.sv
module seg_adder #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  localparam int ADDR_W = SEG_W + SHIFT
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [OFF_W-1:0]  ofs,
  output logic [ADDR_W-1:0] addr,
  output logic              wrap_evt
);
  function automatic logic [ADDR_W:0] full_sum(input logic [SEG_W-1:0] s,
                                                input logic [OFF_W-1:0] o);
    logic [ADDR_W:0] base;
    base = {1'b0, s, {SHIFT{1'b0}}};
    return base + (ADDR_W+1)'(o);
  endfunction

  logic [ADDR_W:0] sum;
  assign sum      = full_sum(seg, ofs);
  assign addr     = sum[ADDR_W-1:0];
  assign wrap_evt = sum[ADDR_W];
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   seg_wr_en,
  input  logic [1:0]             seg_wr_sel,
  input  logic [SEG_W-1:0]       seg_wr_data,
  input  logic [2:0]             ofs_src,
  input  logic [OFF_W-1:0]       ofs_val,
  input  logic                   ovr_en,
  input  logic [1:0]             ovr_sel,
  output logic [SEG_W+SHIFT-1:0] phys_addr
);
  localparam int ADDR_W = SEG_W + SHIFT;

  logic [NUM_SEGS-1:0][SEG_W-1:0] seg_q;
  logic [SEL_W-1:0]               eff_seg;
  logic                           ovr_taken;
  logic [SEG_W-1:0]               seg_val;
  logic                           wrap_evt;

  seg_regfile #(.NSEG(NUM_SEGS), .SEG_W(SEG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(seg_wr_en), .wr_sel(seg_wr_sel),
    .wr_data(seg_wr_data), .seg_q(seg_q)
  );

  seg_selector u_sel (
    .src(ofs_src), .ovr_en(ovr_en), .ovr_sel(ovr_sel),
    .seg_sel(eff_seg), .ovr_taken(ovr_taken)
  );

  assign seg_val = seg_q[eff_seg];

  seg_adder #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_add (
    .seg(seg_val), .ofs(ofs_val), .addr(phys_addr), .wrap_evt(wrap_evt)
  );

  // R8
  str_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ofs_src == SRC_STRDST) |-> (eff_seg == SEG_EXTRA && !ovr_taken));

  // R7
  override_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_en && ofs_src != SRC_STRDST) |-> (eff_seg == ovr_sel));

  // R1
  low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phys_addr[SHIFT-1:0] == ofs_val[SHIFT-1:0]);

  // R2
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |-> (phys_addr < {seg_val, {SHIFT{1'b0}}}));
endmodule

// File: tb/seg_addr_gen_test.sv
module seg_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seg_wr_en = 1'b0;
  logic [1:0]  seg_wr_sel = '0;
  logic [15:0] seg_wr_data = '0;
  logic [2:0]  ofs_src = '0;
  logic [15:0] ofs_val = '0;
  logic        ovr_en = 1'b0;
  logic [1:0]  ovr_sel = '0;
  logic [19:0] phys_addr;

  int checks = 0;
  int failures = 0;
  logic [15:0] shadow [4];

  always #4 clk = ~clk;

  seg_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel),
    .seg_wr_data(seg_wr_data), .ofs_src(ofs_src), .ofs_val(ofs_val),
    .ovr_en(ovr_en), .ovr_sel(ovr_sel), .phys_addr(phys_addr)
  );

  function automatic int expect_addr(input logic [15:0] s, input logic [15:0] o);
    return (int'(s) * 16 + int'(o)) % 1048576;
  endfunction

  function automatic int pick_seg(input int src, input bit oe, input int os);
    if (src == 5) return 2;
    if (oe) return os;
    if (src == 0) return 0;
    if (src == 1 || src == 2) return 3;
    return 1;
  endfunction

  task automatic check(input string tag, input int exp);
    checks++;
    if (int'(phys_addr) != exp) begin
      failures++;
      $display("FAIL %s: phys_addr=%05h expected=%05h (src=%0d ofs=%04h ovr=%0b/%0d)",
               tag, phys_addr, exp, ofs_src, ofs_val, ovr_en, ovr_sel);
    end
  endtask

  task automatic apply(input int src, input logic [15:0] o, input bit oe, input int os);
    ofs_src = 3'(src); ofs_val = o; ovr_en = oe; ovr_sel = 2'(os);
    #1;
  endtask

  task automatic write_seg(input int sel, input logic [15:0] d);
    @(negedge clk);
    seg_wr_en = 1'b1; seg_wr_sel = 2'(sel); seg_wr_data = d;
    @(negedge clk);
    seg_wr_en = 1'b0;
    shadow[sel] = d;
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) shadow[i] = 16'h0000;
    // R3: during reset every source yields the bare offset
    repeat (2) @(negedge clk);
    for (int s = 0; s < 8; s++) begin
      apply(s, 16'h1234 + 16'(s), 1'b0, 0);
      check("R3 in reset", 32'h1234 + s);
    end
    rst_n = 1'b1;
    @(negedge clk);
    apply(0, 16'hFFFF, 1'b0, 0);
    check("R3 after reset", 32'h0FFFF);

    // R1: worked example
    write_seg(0, 16'h34BA);
    apply(0, 16'h8AB4, 1'b0, 0);
    check("R1 example", 32'h3D654);

    // R5: load each other register and confirm neighbours untouched
    write_seg(1, 16'h1234);
    write_seg(2, 16'hABCD);
    write_seg(3, 16'hFFFF);
    for (int r = 0; r < 4; r++) begin
      apply(0, 16'h0000, 1'b1, r);
      check("R5 register contents", expect_addr(shadow[r], 16'h0000));
    end

    // R6 R7 R8 R9: sweep of source, override and offsets
    for (int s = 0; s < 8; s++)
      for (int oe = 0; oe < 2; oe++)
        for (int os = 0; os < 4; os++)
          for (int k = 0; k < 6; k++) begin
            logic [15:0] o;
            int seg;
            o = 16'(k * 16'h3339 + s * 7 + os);
            seg = pick_seg(s, oe[0], os);
            apply(s, o, oe[0], os);
            if (s == 5) check("R8 string destination", expect_addr(shadow[2], o));
            else if (oe != 0) check("R7 override", expect_addr(shadow[seg], o));
            else check("R6 default mapping", expect_addr(shadow[seg], o));
          end

    // R9: offset change seen without a clock edge
    @(negedge clk);
    apply(3, 16'h0001, 1'b0, 0);
    ofs_val = 16'h0100; #1;
    check("R9 same-cycle offset", expect_addr(shadow[1], 16'h0100));
    ovr_en = 1'b1; ovr_sel = 2'd2; #1;
    check("R9 same-cycle override", expect_addr(shadow[2], 16'h0100));

    // R2: wrap-around cases on stack = FFFF
    apply(1, 16'h0010, 1'b0, 0);
    check("R2 wrap to zero", 32'h00000);
    apply(2, 16'hFFFF, 1'b0, 0);
    check("R2 wrap high offset", 32'h0FFEF);
    apply(2, 16'h000F, 1'b0, 0);
    check("R2 no wrap top", 32'hFFFFF);

    // R4: write and lookup of the same register in one cycle
    @(negedge clk);
    apply(4, 16'h0040, 1'b0, 0);
    seg_wr_en = 1'b1; seg_wr_sel = 2'd1; seg_wr_data = 16'h5000; #1;
    check("R4 old value during write", expect_addr(16'h1234, 16'h0040));
    @(negedge clk);
    seg_wr_en = 1'b0; shadow[1] = 16'h5000; #1;
    check("R4 new value after edge", expect_addr(16'h5000, 16'h0040));
    apply(0, 16'h0000, 1'b0, 0);
    check("R5 code untouched", expect_addr(16'h34BA, 16'h0000));
    apply(5, 16'h0000, 1'b0, 0);
    check("R5 extra untouched", expect_addr(16'hABCD, 16'h0000));

    // R3: reset again clears every register
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int r = 0; r < 4; r++) begin
      apply(0, 16'h0ABC, 1'b1, r);
      check("R3 cleared by reset", 32'h00ABC);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule